// File: doc/BRIEF.md
# Pulse-Train Code Memory Programming Sequencer

This block writes one byte into a byte-wide on-chip programmable code memory. It uses a train of short, fixed-length programming strobes instead of one long pulse. A single start command captures a target selector, an address and a data byte. The sequencer then presents the address and data to the array and lets them settle. It switches on the high programming voltage and, after a settling window, issues a fixed number of active-low strobes separated by enforced high gaps. It then keeps the voltage on for a hold window and removes it. Finally it reads the byte back with an active-low read enable and compares the result with the byte it wrote.

The same sequence serves three targets: the main code array, the encryption table and the lock bits. Lock bits cannot be read back, so for them the read-back is skipped and the run reports pass. All microsecond windows are turned into clock cycles by a cycles-per-microsecond parameter. The oscillator-period windows (address/data setup, hold and read settling) are counted directly in clock cycles. The memory array and the voltage generator are outside the block.

Top module: `eprog_seq`

## Requirements
- R1: Every accepted command produces exactly NUM_PULSES (default 25) falling edges on `pgm_n_o`.
- R2: Each strobe keeps `pgm_n_o` low for exactly PULSE_US x CYC_PER_US clock cycles (default 100 us).
- R3: Between two consecutive strobes `pgm_n_o` stays high for exactly GAP_US x CYC_PER_US cycles (default 10 us).
- R4: `vpp_en_o` rises exactly VPP_SETUP_US x CYC_PER_US cycles before the first strobe falls. It stays high for exactly VPP_HOLD_US x CYC_PER_US cycles after the last strobe rises, and then drops.
- R5: `mem_addr_o`/`mem_wdata_o` are captured at start and stay constant while busy. `bus_drive_o` is high for at least ADDR_SETUP_CYC cycles before the first strobe falls and for at least ADDR_HOLD_CYC cycles after the last strobe rises.
- R6: For the code (`target_i` = 2'b00) and encryption (2'b01) targets, `rd_n_o` goes low for exactly VERIFY_CYC cycles after `vpp_en_o` has dropped. It is never low while `vpp_en_o` is high. `rdata_i` is compared with the written byte in the last cycle of that window.
- R7: `done_o` is a one-cycle pulse at the end of each run. At that moment exactly one of `pass_o` (read-back equals written byte) and `fail_o` (mismatch) is high. Both flags hold until the next accepted start.
- R8: For the lock-bit targets (`target_i[1]` = 1) the run performs no read (`rd_n_o` stays high) and ends with `pass_o` high.
- R9: A start pulse while `busy_o` is high is ignored: captured address, data and target stay unchanged, and no additional run follows.
- R10: While reset is low, and directly after it, `vpp_en_o` = 0, `pgm_n_o` = 1, `rd_n_o` = 1, and `busy_o`, `done_o`, `pass_o`, `fail_o` and `bus_drive_o` are 0. A reset in mid-run aborts the run at once.
- R11: `pgm_n_o` is never low unless `vpp_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, sampled only when idle |
| target_i | input | 2 | 00 code array, 01 encryption table, 1x lock bits |
| addr_i | input | ADDR_W | Byte address to program |
| wdata_i | input | DATA_W | Byte to program |
| rdata_i | input | DATA_W | Read-back data from the array |
| vpp_en_o | output | 1 | Programming voltage enable |
| pgm_n_o | output | 1 | Active-low programming strobe |
| bus_drive_o | output | 1 | Address/data presented to the array |
| rd_n_o | output | 1 | Active-low read-back enable |
| tgt_o | output | 2 | Captured target selector |
| mem_addr_o | output | ADDR_W | Captured address |
| mem_wdata_o | output | DATA_W | Captured data byte |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Read-back matched (or lock target) |
| fail_o | output | 1 | Read-back mismatch |

## Verification
The bench builds the block with CYC_PER_US = 1, so every microsecond window becomes an exact, small cycle count. Strobe widths, gaps and supply setup/hold can then be counted edge by edge in a few thousand cycles per byte. The oscillator-period windows stay at their default 48 cycles, and ADDR_W = 6 lets a behavioural array model in the bench cover every address. That model clears bits on each strobe, as an erasable memory does. Reprogramming a location with a byte that needs a 0-to-1 change therefore produces a genuine verify mismatch, which exercises the fail path without any fault injection.

// File: rtl/eprog_pkg.sv
package eprog_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ASET,
    S_VSET,
    S_PLS,
    S_GAP,
    S_VHLD,
    S_AHLD,
    S_VRFY,
    S_DONE
  } seq_state_e;

  // Microsecond window to clock cycles
  function automatic int us_cycles(input int us, input int cyc_per_us);
    return us * cyc_per_us;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Targets with bit 1 set are the lock bits: no read-back
  function automatic logic is_lock(input logic [1:0] tgt);
    return tgt[1];
  endfunction

endpackage

// File: rtl/eprog_dwell.sv
module eprog_dwell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/eprog_pulse_ctr.sv
module eprog_pulse_ctr #(
  parameter int N = 25,
  localparam int W = $clog2(N + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end

  // High while the strobe in progress is the final one
  assign last = (cnt_q == W'(N - 1));
endmodule

// File: rtl/eprog_verify.sv
module eprog_verify #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          sample,
  input  logic          bypass,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] expected,
  output logic          pass,
  output logic          fail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass <= 1'b0;
      fail <= 1'b0;
    end else if (clr) begin
      pass <= 1'b0;
      fail <= 1'b0;
    end else if (bypass) begin
      pass <= 1'b1;
      fail <= 1'b0;
    end else if (sample) begin
      pass <= (rdata == expected);
      fail <= (rdata != expected);
    end
  end
endmodule

// File: rtl/eprog_seq.sv
module eprog_seq
  import eprog_pkg::*;
#(
  parameter int ADDR_W         = 13,
  parameter int DATA_W         = 8,
  parameter int CYC_PER_US     = 12,
  parameter int NUM_PULSES     = 25,
  parameter int PULSE_US       = 100,
  parameter int GAP_US         = 10,
  parameter int VPP_SETUP_US   = 10,
  parameter int VPP_HOLD_US    = 10,
  parameter int ADDR_SETUP_CYC = 48,
  parameter int ADDR_HOLD_CYC  = 48,
  parameter int VERIFY_CYC     = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        target_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              vpp_en_o,
  output logic              pgm_n_o,
  output logic              bus_drive_o,
  output logic              rd_n_o,
  output logic [1:0]        tgt_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o
);
  localparam int PULSE_CYC = us_cycles(PULSE_US, CYC_PER_US);
  localparam int GAP_CYC   = us_cycles(GAP_US, CYC_PER_US);
  localparam int VSET_CYC  = us_cycles(VPP_SETUP_US, CYC_PER_US);
  localparam int VHLD_CYC  = us_cycles(VPP_HOLD_US, CYC_PER_US);
  localparam int MAX_DWELL = max_of(max_of(max_of(PULSE_CYC, GAP_CYC),
                                           max_of(VSET_CYC, VHLD_CYC)),
                                    max_of(max_of(ADDR_SETUP_CYC, ADDR_HOLD_CYC),
                                           VERIFY_CYC));
  localparam int TW = $clog2(MAX_DWELL + 1);

  seq_state_e        st_q, st_nxt;
  logic              accept, tmr_load, tmr_expired, last_pulse;
  logic              pulse_end, verify_sample, lock_bypass;
  logic [TW-1:0]     tmr_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        tgt_q;

  // Dwell time of each state, minus one (timer counts down to zero)
  function automatic logic [TW-1:0] dwell(input seq_state_e s);
    case (s)
      S_ASET:  return TW'(ADDR_SETUP_CYC - 1);
      S_VSET:  return TW'(VSET_CYC - 1);
      S_PLS:   return TW'(PULSE_CYC - 1);
      S_GAP:   return TW'(GAP_CYC - 1);
      S_VHLD:  return TW'(VHLD_CYC - 1);
      S_AHLD:  return TW'(ADDR_HOLD_CYC - 1);
      S_VRFY:  return TW'(VERIFY_CYC - 1);
      default: return '0;
    endcase
  endfunction

  assign accept = (st_q == S_IDLE) && start_i;

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      S_IDLE: if (start_i)     st_nxt = S_ASET;
      S_ASET: if (tmr_expired) st_nxt = S_VSET;
      S_VSET: if (tmr_expired) st_nxt = S_PLS;
      S_PLS:  if (tmr_expired) st_nxt = last_pulse ? S_VHLD : S_GAP;
      S_GAP:  if (tmr_expired) st_nxt = S_PLS;
      S_VHLD: if (tmr_expired) st_nxt = S_AHLD;
      S_AHLD: if (tmr_expired) st_nxt = is_lock(tgt_q) ? S_DONE : S_VRFY;
      S_VRFY: if (tmr_expired) st_nxt = S_DONE;
      S_DONE:                  st_nxt = S_IDLE;
      default:                 st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      tgt_q  <= '0;
    end else if (accept) begin
      addr_q <= addr_i;
      data_q <= wdata_i;
      tgt_q  <= target_i;
    end
  end

  assign tmr_load      = (st_nxt != st_q);
  assign tmr_val       = dwell(st_nxt);
  assign pulse_end     = (st_q == S_PLS) && tmr_expired;
  assign verify_sample = (st_q == S_VRFY) && tmr_expired;
  assign lock_bypass   = (st_q == S_AHLD) && tmr_expired && is_lock(tgt_q);

  eprog_dwell #(.W(TW)) u_dwell (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  eprog_pulse_ctr #(.N(NUM_PULSES)) u_pulses (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   (pulse_end),
    .last  (last_pulse)
  );

  eprog_verify #(.DW(DATA_W)) u_verify (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .sample   (verify_sample),
    .bypass   (lock_bypass),
    .rdata    (rdata_i),
    .expected (data_q),
    .pass     (pass_o),
    .fail     (fail_o)
  );

  assign vpp_en_o    = (st_q == S_VSET) || (st_q == S_PLS) ||
                       (st_q == S_GAP)  || (st_q == S_VHLD);
  assign pgm_n_o     = (st_q != S_PLS);
  assign bus_drive_o = vpp_en_o || (st_q == S_ASET) || (st_q == S_AHLD);
  assign rd_n_o      = (st_q != S_VRFY);
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = (st_q == S_DONE);
  assign tgt_o       = tgt_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;
endmodule

// File: rtl/eprog_seq_chk.sv
module eprog_seq_chk #(
  parameter int ADDR_W     = 13,
  parameter int NUM_PULSES = 25,
  parameter int PULSE_CYC  = 1200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vpp_en_o,
  input logic              pgm_n_o,
  input logic              rd_n_o,
  input logic [1:0]        tgt_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o
);
  logic pgm_prev;
  int   fall_cnt;
  int   low_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_prev <= 1'b1;
      fall_cnt <= 0;
      low_len  <= 0;
    end else begin
      pgm_prev <= pgm_n_o;
      if (!busy_o)                  fall_cnt <= 0;
      else if (pgm_prev && !pgm_n_o) fall_cnt <= fall_cnt + 1;
      low_len <= pgm_n_o ? 0 : low_len + 1;
    end
  end

  AST_STROBE_NEEDS_VPP: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_n_o |-> vpp_en_o);  // R11

  AST_READ_WITHOUT_VPP: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !vpp_en_o);  // R6

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(mem_addr_o));  // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R7

  AST_RESULT_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $countones({pass_o, fail_o}) == 1);  // R7

  AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> fall_cnt == NUM_PULSES);  // R1

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgm_n_o) |-> low_len == PULSE_CYC);  // R2

  AST_LOCK_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && tgt_o[1] |-> rd_n_o);  // R8
endmodule

bind eprog_seq eprog_seq_chk #(
  .ADDR_W     (ADDR_W),
  .NUM_PULSES (NUM_PULSES),
  .PULSE_CYC  (PULSE_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vpp_en_o   (vpp_en_o),
  .pgm_n_o    (pgm_n_o),
  .rd_n_o     (rd_n_o),
  .tgt_o      (tgt_o),
  .mem_addr_o (mem_addr_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .pass_o     (pass_o),
  .fail_o     (fail_o)
);

// File: tb/eprog_seq_bench.sv
module eprog_seq_bench;
  localparam int AW     = 6;
  localparam int DW     = 8;
  localparam int NP     = 25;
  localparam int P_LOW  = 100;  // 100 us at 1 cycle per us
  localparam int P_GAP  = 10;
  localparam int P_VSET = 10;
  localparam int P_VHLD = 10;
  localparam int P_ASU  = 48;
  localparam int P_AHD  = 48;
  localparam int P_VRF  = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    target_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_i;
  logic vpp_en_o, pgm_n_o, bus_drive_o, rd_n_o, busy_o, done_o, pass_o, fail_o;
  logic [1:0]    tgt_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;

  always #2.5 clk = ~clk;  // 200 MHz

  eprog_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CYC_PER_US(1), .NUM_PULSES(NP),
    .PULSE_US(P_LOW), .GAP_US(P_GAP), .VPP_SETUP_US(P_VSET), .VPP_HOLD_US(P_VHLD),
    .ADDR_SETUP_CYC(P_ASU), .ADDR_HOLD_CYC(P_AHD), .VERIFY_CYC(P_VRF)
  ) u_eprog_seq (.*);

  // Behavioural array: a strobe can only clear bits
  logic [DW-1:0] code_mem [64];
  logic [DW-1:0] crypt_mem [32];
  logic [DW-1:0] lock_mem [64];

  always_comb begin
    rdata_i = '1;
    if (!rd_n_o) begin
      if (tgt_o == 2'b00)      rdata_i = code_mem[mem_addr_o];
      else if (tgt_o == 2'b01) rdata_i = crypt_mem[mem_addr_o[4:0]];
    end
  end

  int n_chk = 0, n_fail = 0;
  int n_pulses, low_run, high_run, min_low, max_low, min_gap, max_gap;
  int vpp_before, vpp_after, drv_before, drv_after, rd_len, rd_vpp, addr_chg, n_done;
  logic pgm_prev = 1'b1, drv_prev = 1'b0;
  logic [AW-1:0] addr_prev = '0;

  task automatic mon_clear();
    n_pulses = 0; low_run = 0; high_run = 0;
    min_low = 1 << 30; max_low = 0; min_gap = 1 << 30; max_gap = 0;
    vpp_before = 0; vpp_after = 0; drv_before = 0; drv_after = 0;
    rd_len = 0; rd_vpp = 0; addr_chg = 0; n_done = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!pgm_n_o) begin
        if (pgm_prev) begin
          if (n_pulses > 0) begin
            if (high_run < min_gap) min_gap = high_run;
            if (high_run > max_gap) max_gap = high_run;
          end
          n_pulses++;
          low_run = 1; vpp_after = 0; drv_after = 0;
          if (vpp_en_o) begin
            if (tgt_o == 2'b00)      code_mem[mem_addr_o] &= mem_wdata_o;
            else if (tgt_o == 2'b01) crypt_mem[mem_addr_o[4:0]] &= mem_wdata_o;
            else                     lock_mem[mem_addr_o] &= mem_wdata_o;
          end
        end else low_run++;
      end else begin
        if (!pgm_prev) begin
          if (low_run < min_low) min_low = low_run;
          if (low_run > max_low) max_low = low_run;
          high_run = 1;
        end else high_run++;
        if (n_pulses > 0 && vpp_en_o)    vpp_after++;
        if (n_pulses > 0 && bus_drive_o) drv_after++;
      end
      if (n_pulses == 0 && vpp_en_o)    vpp_before++;
      if (n_pulses == 0 && bus_drive_o) drv_before++;
      if (!rd_n_o) rd_len++;
      if (!rd_n_o && vpp_en_o) rd_vpp++;
      if (drv_prev && bus_drive_o && mem_addr_o != addr_prev) addr_chg++;
      if (done_o) n_done++;
    end
    pgm_prev  = pgm_n_o;
    drv_prev  = bus_drive_o;
    addr_prev = mem_addr_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endfunction

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  task automatic issue(input logic [1:0] t, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    mon_clear();
    target_i = t; addr_i = a; wdata_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  task automatic check_run(input logic [1:0] t, input bit exp_pass);
    check(n_pulses == NP, "R1 pulse count", n_pulses, NP);
    check(min_low == P_LOW && max_low == P_LOW, "R2 low width", max_low, P_LOW);
    check(min_gap == P_GAP && max_gap == P_GAP, "R3 gap width", min_gap, P_GAP);
    check(vpp_before == P_VSET, "R4 vpp setup", vpp_before, P_VSET);
    check(vpp_after == P_VHLD, "R4 vpp hold", vpp_after, P_VHLD);
    check(drv_before >= P_ASU, "R5 addr setup", drv_before, P_ASU);
    check(drv_after >= P_AHD, "R5 addr hold", drv_after, P_AHD);
    check(addr_chg == 0, "R5 addr stable", addr_chg, 0);
    check(rd_vpp == 0, "R6 read under vpp", rd_vpp, 0);
    if (t[1]) check(rd_len == 0, "R8 lock no read", rd_len, 0);
    else      check(rd_len == P_VRF, "R6 read window", rd_len, P_VRF);
    check(pass_o == exp_pass, "R7 pass", pass_o, exp_pass);
    check(fail_o == !exp_pass, "R7 fail", fail_o, !exp_pass);
    @(negedge clk);
    check(!done_o && !busy_o, "R7 done single cycle", done_o, 0);
    check(pass_o == exp_pass, "R7 flag held", pass_o, exp_pass);
  endtask

  // {target[1:0], addr[5:0], data[7:0], expected pass}
  localparam logic [16:0] VEC [9] = '{
    {2'b00, 6'h03, 8'hA5, 1'b1},
    {2'b00, 6'h10, 8'h00, 1'b1},
    {2'b00, 6'h03, 8'hA4, 1'b1},
    {2'b00, 6'h03, 8'h5A, 1'b0},  // needs 0->1: mismatch
    {2'b01, 6'h07, 8'h3C, 1'b1},
    {2'b01, 6'h07, 8'hC3, 1'b0},
    {2'b10, 6'h00, 8'hFE, 1'b1},  // lock: R8
    {2'b00, 6'h3F, 8'hFF, 1'b1},
    {2'b11, 6'h01, 8'hFD, 1'b1}
  };

  initial begin
    for (int i = 0; i < 64; i++) begin code_mem[i] = '1; lock_mem[i] = '1; end
    for (int i = 0; i < 32; i++) crypt_mem[i] = '1;
    mon_clear();

    // R10: reset state
    repeat (3) @(negedge clk);
    check(!vpp_en_o && pgm_n_o && rd_n_o && !bus_drive_o, "R10 reset pins", vpp_en_o, 0);
    check(!busy_o && !done_o && !pass_o && !fail_o, "R10 reset status", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && pgm_n_o && !vpp_en_o, "R10 after release", busy_o, 0);

    for (int i = 0; i < 9; i++) begin
      issue(VEC[i][16:15], VEC[i][14:9], VEC[i][8:1]);
      wait_done();
      check_run(VEC[i][16:15], VEC[i][0]);
    end

    // R9: start while busy is ignored
    issue(2'b00, 6'h20, 8'h11);
    repeat (100) @(negedge clk);
    target_i = 2'b01; addr_i = 6'h21; wdata_i = 8'h00; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(mem_addr_o == 6'h20 && tgt_o == 2'b00, "R9 capture kept", mem_addr_o, 6'h20);
    wait_done();
    check_run(2'b00, 1'b1);
    mon_clear();
    repeat (3000) @(negedge clk);
    check(n_done == 0 && n_pulses == 0, "R9 no second run", n_done, 0);
    check(crypt_mem[1] == 8'hFF && code_mem[6'h21] == 8'hFF, "R9 untouched", crypt_mem[1], 8'hFF);
    check(code_mem[6'h20] == 8'h11, "R9 first byte written", code_mem[6'h20], 8'h11);

    // R10: reset in mid-run aborts at once
    issue(2'b00, 6'h2A, 8'h00);
    while (pgm_n_o) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!vpp_en_o && pgm_n_o && !busy_o && !bus_drive_o, "R10 abort", vpp_en_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!busy_o && !pass_o && !fail_o, "R10 idle after abort", busy_o, 0);

    summary();
    $finish;
  end
endmodule